// File: doc/BRIEF.md
# Flash Unlock Command Sequencer

This block sits in front of a byte-wide parallel flash array and interprets the stream of bus writes it receives. Each write carries a 19-bit address and an 8-bit data byte. The block watches for multi-write unlock codes and moves between four modes: plain reading, sector loading, identification, and arming of the boot-region lock. While loading, it passes each write on to the sector loader. A write aimed at a boot region that has been locked is refused instead.

Command writes are matched on the low fifteen address bits and on the whole data byte. Any write that breaks a sequence sends the matcher back to idle. That same write is then tested again as a possible first step. In identification mode a read mux returns the maker and device codes and the lock status of each boot region. The lock bits hold until reset. Once either lock bit is set, the chip-erase command is ignored. An external `prog_done` pulse ends a sector load, and the block then requires the whole unlock code again.

Top module: `flash_cmd_seq`

## Requirements
- R1: After a synchronous active-low reset, `mode` is 0 (read), both lock bits are 0, `load_valid`, `load_reject` and `erase_go` are 0, and `id_rdata` is 00h.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h put `mode` at 1 (load) in the cycle after the third write. Only address bits 14:0 are compared, so bits 18:15 of command writes may hold any value.
- R3: In load mode, every write appears one cycle later as a `load_valid` pulse with its address on `load_addr` and its data on `load_data`. Command codes are not matched in this mode. A `prog_done` pulse returns `mode` to 0 one cycle later. A write presented in the same cycle as `prog_done` is still forwarded.
- R4: Outside load mode, no write produces `load_valid`.
- R5: A write that does not match the expected step aborts the sequence. If that write is itself AAh@5555h, it counts as a new first step.
- R6: The writes AAh@5555h, 55h@2AAAh, 90h@5555h set `mode` to 2 (identification). In that mode a read of address 0 gives 1Fh and a read of address 1 gives C4h. The writes AAh@5555h, 55h@2AAAh, F0h@5555h return `mode` to 0. No other completed code has any effect while in identification mode.
- R7: In identification mode, a read of 00002h reports the lower region and a read of 7FFF2h reports the upper region. Each reads FEh when its region is unlocked and FFh when it is locked.
- R8: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 40h@5555h set `mode` to 3 (arm). The next write then returns `mode` to 0. If that write is 00h@00000h it sets `lock_lo`; if it is FFh@7FFFFh it sets `lock_hi`. Any other write sets no bit and is not tested as a command step.
- R9: Once set, a lock bit stays set until reset.
- R10: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h give a one-cycle `erase_go` pulse after the sixth write, but only while both lock bits are 0.
- R11: In load mode, a write whose address bits 18:14 are all zero while `lock_lo` is set, or all one while `lock_hi` is set, gives a `load_reject` pulse and no `load_valid`.
- R12: `id_rdata` is 00h for any other address in identification mode, and for every address outside identification mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data |
| prog_done | input | 1 | Sector program cycle finished |
| rd_addr | input | 19 | Read address for the identification mux |
| mode | output | 2 | 0 read, 1 load, 2 identification, 3 lock armed |
| lock_lo | output | 1 | Lower 16 KB region locked |
| lock_hi | output | 1 | Upper 16 KB region locked |
| load_valid | output | 1 | Forwarded byte load pulse |
| load_reject | output | 1 | Load refused, locked region |
| load_addr | output | 19 | Address of the last load write |
| load_data | output | 8 | Data of the last load write |
| erase_go | output | 1 | Chip-erase request pulse |
| id_rdata | output | 8 | Identification read data |

## Verification
Two functions can fall in the same cycle: the end of a program cycle (`prog_done`) and a byte load. The random phase sometimes presents the last load of a sector in the same cycle as `prog_done`. The bench then expects that byte to be forwarded, `mode` to read 0 one cycle later, and the next write to be treated as a command step. A directed case checks the same collision for a write into a locked region, which must give `load_reject` and still leave load mode.

// File: rtl/flash_seq_pkg.sv
// Package: shared mode and command codes for the flash command sequencer.
// Assumes 8-bit command data; the address keys are supplied as module parameters.
package flash_seq_pkg;
    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_IDENT = 2'd2,
        MODE_ARM   = 2'd3
    } fmode_t;

    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_PROG     = 3'd1,
        CMD_ID_ENTER = 3'd2,
        CMD_ID_LEAVE = 3'd3,
        CMD_LOCK_ARM = 3'd4,
        CMD_ERASE    = 3'd5
    } fcmd_t;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] OP_PROG    = 8'hA0;
    localparam logic [7:0] OP_ID_IN   = 8'h90;
    localparam logic [7:0] OP_ID_OUT  = 8'hF0;
    localparam logic [7:0] OP_EXTEND  = 8'h80;
    localparam logic [7:0] OP_LOCK    = 8'h40;
    localparam logic [7:0] OP_ERASE   = 8'h10;
endpackage

// File: rtl/flash_cmd_match.sv
// Module: command sequence matcher.
// Tracks progress through the three-write and six-write unlock codes and reports
// a completed command combinationally in the cycle of its final write.
// Assumes run is low whenever writes must not be read as commands; a mismatching
// write is retried as a first step.
module flash_cmd_match
    import flash_seq_pkg::*;
#(
    parameter int CMD_AW = 15,
    parameter logic [CMD_AW-1:0] ADR_MAIN = 15'h5555,
    parameter logic [CMD_AW-1:0] ADR_ALT  = 15'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_en,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [7:0]        wr_data,
    output fcmd_t             cmd
);
    logic [2:0] step_q, step_n;
    logic       at_main, at_alt, first_hit;

    // Decode the address keys and the first unlock step.
    always_comb begin
        at_main   = (cmd_addr == ADR_MAIN);
        at_alt    = (cmd_addr == ADR_ALT);
        first_hit = at_main && (wr_data == KEY_FIRST);
    end

    // Compute the next step and any completed command.
    always_comb begin
        cmd    = CMD_NONE;
        step_n = step_q;
        if (!run) begin
            step_n = 3'd0;
        end else if (wr_en) begin
            step_n = first_hit ? 3'd1 : 3'd0;
            case (step_q)
                3'd1: if (at_alt && wr_data == KEY_SECOND) step_n = 3'd2;
                3'd2: if (at_main) begin
                    case (wr_data)
                        OP_PROG:   begin cmd = CMD_PROG;     step_n = 3'd0; end
                        OP_ID_IN:  begin cmd = CMD_ID_ENTER; step_n = 3'd0; end
                        OP_ID_OUT: begin cmd = CMD_ID_LEAVE; step_n = 3'd0; end
                        OP_EXTEND: step_n = 3'd3;
                        default:   ;
                    endcase
                end
                3'd3: if (first_hit) step_n = 3'd4;
                3'd4: if (at_alt && wr_data == KEY_SECOND) step_n = 3'd5;
                3'd5: if (at_main) begin
                    case (wr_data)
                        OP_LOCK:  begin cmd = CMD_LOCK_ARM; step_n = 3'd0; end
                        OP_ERASE: begin cmd = CMD_ERASE;    step_n = 3'd0; end
                        default:  ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= 3'd0;
        else        step_q <= step_n;
    end
endmodule

// File: rtl/flash_boot_guard.sv
// Module: boot region guard.
// Flags an address that falls in the lowest or highest boot region while that
// region is locked. Assumes each region spans 2**BOOT_AW bytes at one end of the map.
module flash_boot_guard #(
    parameter int ADDR_W  = 19,
    parameter int BOOT_AW = 14
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              lock_lo,
    input  logic              lock_hi,
    output logic              blocked
);
    localparam int REGION_W = ADDR_W - BOOT_AW;
    logic [REGION_W-1:0] region;

    // Compare the region bits against both ends of the map.
    always_comb begin
        region  = addr[ADDR_W-1:BOOT_AW];
        blocked = (lock_lo && region == '0) || (lock_hi && region == '1);
    end
endmodule

// File: rtl/flash_id_mux.sv
// Module: identification read mux.
// Returns the maker and device codes and the per-region lock status while active.
// Returns zero otherwise. Assumes a combinational read path.
module flash_id_mux #(
    parameter int ADDR_W = 19,
    parameter logic [7:0] MFR_CODE = 8'h1F,
    parameter logic [7:0] DEV_CODE = 8'hC4
) (
    input  logic              active,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              lock_lo,
    input  logic              lock_hi,
    output logic [7:0]        rdata
);
    localparam logic [ADDR_W-1:0] ADR_MFR  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_DEV  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADR_STLO = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ADR_STHI = {ADDR_W{1'b1}} ^ ADDR_W'(13);

    // Select the identification byte for the read address.
    always_comb begin
        rdata = 8'h00;
        if (active) begin
            if (rd_addr == ADR_MFR)       rdata = MFR_CODE;
            else if (rd_addr == ADR_DEV)  rdata = DEV_CODE;
            else if (rd_addr == ADR_STLO) rdata = {7'h7F, lock_lo};
            else if (rd_addr == ADR_STHI) rdata = {7'h7F, lock_hi};
        end
    end
endmodule

// File: rtl/flash_mode_ctl.sv
// Module: mode and lock controller.
// Holds the operating mode and the sticky lock bits, and forwards or refuses byte loads.
// Issues the erase request. Assumes cmd is valid only in the cycle of a write in read
// or identification mode.
module flash_mode_ctl
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter logic [7:0] LO_KEY = 8'h00,
    parameter logic [7:0] HI_KEY = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              prog_done,
    input  fcmd_t             cmd,
    input  logic              blocked,
    output fmode_t            mode_q,
    output logic              lock_lo,
    output logic              lock_hi,
    output logic              load_valid,
    output logic              load_reject,
    output logic [ADDR_W-1:0] load_addr,
    output logic [7:0]        load_data,
    output logic              erase_go
);
    // Mode transitions, load forwarding, lock setting and erase request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= MODE_READ;
            lock_lo     <= 1'b0;
            lock_hi     <= 1'b0;
            load_valid  <= 1'b0;
            load_reject <= 1'b0;
            load_addr   <= '0;
            load_data   <= '0;
            erase_go    <= 1'b0;
        end else begin
            load_valid  <= 1'b0;
            load_reject <= 1'b0;
            erase_go    <= 1'b0;
            case (mode_q)
                MODE_LOAD: begin
                    if (wr_en) begin
                        load_addr   <= wr_addr;
                        load_data   <= wr_data;
                        load_valid  <= !blocked;
                        load_reject <= blocked;
                    end
                    if (prog_done) mode_q <= MODE_READ;
                end
                MODE_ARM: begin
                    if (wr_en) begin
                        if (wr_data == LO_KEY && wr_addr == '0)      lock_lo <= 1'b1;
                        else if (wr_data == HI_KEY && wr_addr == '1) lock_hi <= 1'b1;
                        mode_q <= MODE_READ;
                    end
                end
                MODE_IDENT: begin
                    if (cmd == CMD_ID_LEAVE) mode_q <= MODE_READ;
                end
                default: begin
                    case (cmd)
                        CMD_PROG:     mode_q   <= MODE_LOAD;
                        CMD_ID_ENTER: mode_q   <= MODE_IDENT;
                        CMD_LOCK_ARM: mode_q   <= MODE_ARM;
                        CMD_ERASE:    erase_go <= !(lock_lo || lock_hi);
                        default:      ;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
// Module: flash unlock command sequencer (top).
// Ties the matcher, the mode controller, the boot guard and the identification mux together.
// Assumes one write per strobe cycle and a synchronous active-low reset.
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int CMD_AW  = 15,
    parameter int BOOT_AW = 14,
    parameter logic [7:0] MFR_CODE = 8'h1F,
    parameter logic [7:0] DEV_CODE = 8'hC4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              prog_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        mode,
    output logic              lock_lo,
    output logic              lock_hi,
    output logic              load_valid,
    output logic              load_reject,
    output logic [ADDR_W-1:0] load_addr,
    output logic [7:0]        load_data,
    output logic              erase_go,
    output logic [7:0]        id_rdata
);
    fmode_t mode_q;
    fcmd_t  cmd;
    logic   cmd_run, blocked;

    // Commands are decoded only in read and identification modes.
    always_comb begin
        cmd_run = (mode_q == MODE_READ) || (mode_q == MODE_IDENT);
        mode    = mode_q;
    end

    flash_cmd_match #(.CMD_AW(CMD_AW)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cmd_run),
        .wr_en    (wr_en),
        .cmd_addr (wr_addr[CMD_AW-1:0]),
        .wr_data  (wr_data),
        .cmd      (cmd)
    );

    flash_boot_guard #(.ADDR_W(ADDR_W), .BOOT_AW(BOOT_AW)) u_guard (
        .addr    (wr_addr),
        .lock_lo (lock_lo),
        .lock_hi (lock_hi),
        .blocked (blocked)
    );

    flash_mode_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .prog_done   (prog_done),
        .cmd         (cmd),
        .blocked     (blocked),
        .mode_q      (mode_q),
        .lock_lo     (lock_lo),
        .lock_hi     (lock_hi),
        .load_valid  (load_valid),
        .load_reject (load_reject),
        .load_addr   (load_addr),
        .load_data   (load_data),
        .erase_go    (erase_go)
    );

    flash_id_mux #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_idmux (
        .active  (mode_q == MODE_IDENT),
        .rd_addr (rd_addr),
        .lock_lo (lock_lo),
        .lock_hi (lock_hi),
        .rdata   (id_rdata)
    );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
// Module: property checker for the flash command sequencer, attached by bind.
// Assumes the mode encoding of the shared package.
module flash_cmd_seq_chk #(
    parameter int ADDR_W  = 19,
    parameter int BOOT_AW = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              lock_lo,
    input logic              lock_hi,
    input logic              load_valid,
    input logic              load_reject,
    input logic [ADDR_W-1:0] load_addr,
    input logic              erase_go
);
    // R11
    valid_reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_valid && load_reject));
    // R11
    reject_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_reject |-> ((lock_lo && load_addr[ADDR_W-1:BOOT_AW] == '0) ||
                         (lock_hi && load_addr[ADDR_W-1:BOOT_AW] == '1)));
    // R9
    lock_lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_lo |=> lock_lo);
    // R9
    lock_hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_hi |=> lock_hi);
    // R8
    lock_from_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lock_lo) || $rose(lock_hi)) |-> ($past(mode) == 2'd3 && mode == 2'd0));
    // R3
    load_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid || load_reject) |-> $past(mode) == 2'd1);
    // R2
    load_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && $past(mode) != 2'd1) |-> $past(mode) == 2'd0);
    // R10
    erase_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> (!lock_lo && !lock_hi && mode == 2'd0));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W), .BOOT_AW(BOOT_AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .lock_lo     (lock_lo),
    .lock_hi     (lock_hi),
    .load_valid  (load_valid),
    .load_reject (load_reject),
    .load_addr   (load_addr),
    .erase_go    (erase_go)
);

// File: tb/flash_cmd_seq_tb.sv
// Bench: seeded random command streams checked against a requirement model, then directed corners.
module flash_cmd_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        prog_done = 1'b0;
    logic [18:0] rd_addr = '0;
    logic [1:0]  mode;
    logic        lock_lo, lock_hi, load_valid, load_reject, erase_go;
    logic [18:0] load_addr;
    logic [7:0]  load_data, id_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // model state
    int          m_mode = 0;
    int          m_step = 0;
    bit          m_lo = 0, m_hi = 0;
    bit          e_lv, e_rej, e_er;
    logic [18:0] e_la = '0;
    logic [7:0]  e_ld = '0;

    always #2 clk = ~clk;

    flash_cmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .prog_done(prog_done), .rd_addr(rd_addr), .mode(mode), .lock_lo(lock_lo),
        .lock_hi(lock_hi), .load_valid(load_valid), .load_reject(load_reject),
        .load_addr(load_addr), .load_data(load_data), .erase_go(erase_go), .id_rdata(id_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Command decode written from the requirements: returns 0 none, 1 prog, 2 id in, 3 id out, 4 arm, 5 erase.
    task automatic model_match(input logic [18:0] a, input logic [7:0] d, output int cmd);
        bit k1, k2, am;
        am = (a[14:0] == 15'h5555);
        k1 = am && d == 8'hAA;
        k2 = (a[14:0] == 15'h2AAA) && d == 8'h55;
        cmd = 0;
        if (m_step == 1 && k2) m_step = 2;
        else if (m_step == 2 && am && d inside {8'hA0, 8'h90, 8'hF0}) begin
            cmd = (d == 8'hA0) ? 1 : (d == 8'h90) ? 2 : 3; m_step = 0;
        end
        else if (m_step == 2 && am && d == 8'h80) m_step = 3;
        else if (m_step == 3 && k1) m_step = 4;
        else if (m_step == 4 && k2) m_step = 5;
        else if (m_step == 5 && am && (d == 8'h40 || d == 8'h10)) begin
            cmd = (d == 8'h40) ? 4 : 5; m_step = 0;
        end
        else m_step = k1 ? 1 : 0;
    endtask

    task automatic model_op(input bit wr, input logic [18:0] a, input logic [7:0] d, input bit done);
        int old, cmd;
        bit blk;
        old = m_mode;
        e_lv = 0; e_rej = 0; e_er = 0;
        if (wr) begin
            case (old)
                1: begin
                    blk = (a[18:14] == 5'h00 && m_lo) || (a[18:14] == 5'h1F && m_hi);
                    e_rej = blk; e_lv = !blk; e_la = a; e_ld = d;
                end
                3: begin
                    if (d == 8'h00 && a == 19'h0) m_lo = 1;
                    else if (d == 8'hFF && a == 19'h7FFFF) m_hi = 1;
                    m_mode = 0;
                end
                default: begin
                    model_match(a, d, cmd);
                    if (old == 0) begin
                        if (cmd == 1) m_mode = 1;
                        else if (cmd == 2) m_mode = 2;
                        else if (cmd == 4) m_mode = 3;
                        else if (cmd == 5) e_er = !(m_lo || m_hi);
                    end else if (cmd == 3) m_mode = 0;
                end
            endcase
        end
        if (done && old == 1) m_mode = 0;
    endtask

    task automatic cmp_model();
        chk("R5 mode", 32'(mode), 32'(m_mode));
        chk("R8 lock_lo", 32'(lock_lo), 32'(m_lo));
        chk("R8 lock_hi", 32'(lock_hi), 32'(m_hi));
        chk("R3 load_valid", 32'(load_valid), 32'(e_lv));
        chk("R11 load_reject", 32'(load_reject), 32'(e_rej));
        chk("R10 erase_go", 32'(erase_go), 32'(e_er));
        if (e_lv) begin
            chk("R3 load_addr", 32'(load_addr), 32'(e_la));
            chk("R3 load_data", 32'(load_data), 32'(e_ld));
        end
    endtask

    // Drive one cycle at the falling edge; outputs are read at the next falling edge.
    task automatic op(input bit wr, input logic [18:0] a, input logic [7:0] d, input bit done);
        wr_en = wr; wr_addr = a; wr_data = d; prog_done = done;
        @(negedge clk);
        wr_en = 1'b0; prog_done = 1'b0;
        model_op(wr, a, d, done);
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        op(1'b1, a, d, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        m_mode = 0; m_step = 0; m_lo = 0; m_hi = 0;
        e_lv = 0; e_rej = 0; e_er = 0;
    endtask

    function automatic logic [18:0] cmd_adr(input logic [14:0] low);
        return {4'($urandom_range(0, 15)), low};
    endfunction

    task automatic rand_step(input int k);
        case (k)
            0: wr(cmd_adr(15'h5555), 8'hAA);
            1: wr(cmd_adr(15'h2AAA), 8'h55);
            2: wr(cmd_adr(15'h5555), 8'hA0);
            3: wr(cmd_adr(15'h5555), 8'h90);
            4: wr(cmd_adr(15'h5555), 8'hF0);
            5: wr(cmd_adr(15'h5555), 8'h80);
            6: wr(cmd_adr(15'h5555), 8'h10);
            7: wr(cmd_adr(15'h5555), 8'h40);
            8: if ($urandom_range(0, 1) == 0) wr(19'h0, 8'h00); else wr(19'h7FFFF, 8'hFF);
            default: wr(19'($urandom), 8'($urandom));
        endcase
    endtask

    task automatic id_read(input string tag, input logic [18:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        chk(tag, 32'(id_rdata), 32'(exp));
    endtask

    task automatic unlock3(input logic [7:0] op3);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, op3);
    endtask

    task automatic unlock6(input logic [7:0] op6);
        unlock3(8'h80); wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, op6);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int seq_k [5][6];
        int seq_len [5];
        void'($urandom(32'hC0DE5EED));
        seq_k[0] = '{0, 1, 2, 0, 0, 0}; seq_len[0] = 3;
        seq_k[1] = '{0, 1, 3, 0, 0, 0}; seq_len[1] = 3;
        seq_k[2] = '{0, 1, 4, 0, 0, 0}; seq_len[2] = 3;
        seq_k[3] = '{0, 1, 5, 0, 1, 7}; seq_len[3] = 6;
        seq_k[4] = '{0, 1, 5, 0, 1, 6}; seq_len[4] = 6;
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 mode", 32'(mode), 0);
        chk("R1 lock_lo", 32'(lock_lo), 0);
        chk("R1 lock_hi", 32'(lock_hi), 0);
        chk("R1 load_valid", 32'(load_valid), 0);
        chk("R1 load_reject", 32'(load_reject), 0);
        chk("R1 erase_go", 32'(erase_go), 0);
        id_read("R1 id_rdata", 19'h0, 8'h00);

        // Random phase: whole codes with an occasional corrupted step, loads, done collisions.
        for (int s = 0; s < 300; s++) begin
            int t, bad;
            t = $urandom_range(0, 4);
            bad = ($urandom_range(0, 3) == 0) ? $urandom_range(0, seq_len[t] - 1) : -1;
            for (int i = 0; i < seq_len[t]; i++) begin
                if (i == bad) rand_step($urandom_range(0, 9));
                else rand_step(seq_k[t][i]);
                cmp_model();
            end
            if (m_mode == 3) begin
                rand_step($urandom_range(8, 9));
                cmp_model();
            end
            if (m_mode == 1) begin
                int nl;
                nl = $urandom_range(1, 4);
                for (int j = 0; j < nl; j++) begin
                    logic [18:0] la;
                    la = 19'($urandom);
                    if ($urandom_range(0, 2) == 0) la[18:14] = ($urandom_range(0, 1) == 0) ? 5'h00 : 5'h1F;
                    op(1'b1, la, 8'($urandom), (j == nl - 1) && ($urandom_range(0, 1) == 0));
                    cmp_model();
                end
                if (m_mode == 1) begin
                    op(1'b0, '0, '0, 1'b1);
                    cmp_model();
                end
            end
        end

        // Directed corners from a clean reset.
        do_reset();
        // R2 upper address bits are ignored in command matching
        wr(19'h7D555, 8'hAA); wr(19'h7AAAA, 8'h55);
        chk("R2 mode before third write", 32'(mode), 0);
        wr(19'h4D555, 8'hA0);
        chk("R2 mode load", 32'(mode), 1);
        // R3 forwarding and collision with prog_done
        wr(19'h12345, 8'h5A);
        chk("R3 load_valid", 32'(load_valid), 1);
        chk("R3 load_addr", 32'(load_addr), 32'h12345);
        chk("R3 load_data", 32'(load_data), 32'h5A);
        op(1'b1, 19'h05555, 8'hAA, 1'b1);
        chk("R3 collided load forwarded", 32'(load_valid), 1);
        chk("R3 collided load data", 32'(load_data), 32'hAA);
        chk("R3 mode back to read", 32'(mode), 0);
        // R4 writes outside load mode are not forwarded
        wr(19'h00100, 8'h77);
        chk("R4 no load in read mode", 32'(load_valid), 0);
        chk("R4 mode", 32'(mode), 0);
        // R5 mismatch re-evaluated as first step
        wr(19'h05555, 8'hAA); wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0);
        chk("R5 restart via repeated first step", 32'(mode), 1);
        op(1'b0, '0, '0, 1'b1);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h12);
        wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0);
        chk("R5 aborted sequence", 32'(mode), 0);
        // R12 outside identification mode
        id_read("R12 id_rdata outside ident", 19'h0, 8'h00);
        // R6 identification
        unlock3(8'h90);
        chk("R6 ident mode", 32'(mode), 2);
        id_read("R6 maker code", 19'h0, 8'h1F);
        id_read("R6 device code", 19'h1, 8'hC4);
        id_read("R12 other address", 19'h00005, 8'h00);
        id_read("R7 lower unlocked", 19'h00002, 8'hFE);
        id_read("R7 upper unlocked", 19'h7FFF2, 8'hFE);
        unlock3(8'hA0);
        chk("R6 program code ignored in ident", 32'(mode), 2);
        unlock3(8'hF0);
        chk("R6 exit ident", 32'(mode), 0);
        id_read("R12 after exit", 19'h0, 8'h00);
        // R10 erase while unlocked
        unlock6(8'h10);
        chk("R10 erase pulse", 32'(erase_go), 1);
        @(negedge clk);
        chk("R10 erase pulse one cycle", 32'(erase_go), 0);
        // R8 arm then a wrong key sets nothing
        unlock6(8'h40);
        chk("R8 armed", 32'(mode), 3);
        wr(19'h0, 8'h12);
        chk("R8 wrong key leaves arm", 32'(mode), 0);
        chk("R8 wrong key no lock", 32'(lock_lo), 0);
        unlock6(8'h40);
        wr(19'h0, 8'h00);
        chk("R8 lower lock set", 32'(lock_lo), 1);
        chk("R8 upper still clear", 32'(lock_hi), 0);
        unlock3(8'h90);
        id_read("R7 lower locked", 19'h00002, 8'hFF);
        id_read("R7 upper unlocked", 19'h7FFF2, 8'hFE);
        unlock3(8'hF0);
        // R10 erase ignored once locked
        unlock6(8'h10);
        chk("R10 erase blocked by lock", 32'(erase_go), 0);
        // R11 locked region rejected, others forwarded
        unlock3(8'hA0);
        wr(19'h01234, 8'h33);
        chk("R11 reject low region", 32'(load_reject), 1);
        chk("R11 no forward low region", 32'(load_valid), 0);
        wr(19'h7C000, 8'h44);
        chk("R11 upper unlocked forwarded", 32'(load_valid), 1);
        wr(19'h04000, 8'h55);
        chk("R11 outside region forwarded", 32'(load_valid), 1);
        op(1'b1, 19'h00010, 8'h66, 1'b1);
        chk("R11 reject with done collision", 32'(load_reject), 1);
        chk("R3 mode after done", 32'(mode), 0);
        // R8 upper lock
        unlock6(8'h40);
        wr(19'h7FFFF, 8'hFF);
        chk("R8 upper lock set", 32'(lock_hi), 1);
        unlock3(8'hA0);
        wr(19'h7FFFE, 8'h01);
        chk("R11 reject high region", 32'(load_reject), 1);
        op(1'b0, '0, '0, 1'b1);
        // R9 locks persist through later activity and clear only on reset
        unlock3(8'h90); unlock3(8'hF0);
        chk("R9 lower held", 32'(lock_lo), 1);
        chk("R9 upper held", 32'(lock_hi), 1);
        do_reset();
        chk("R9 reset clears lower", 32'(lock_lo), 0);
        chk("R9 reset clears upper", 32'(lock_hi), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule